// File: doc/BRIEF.md
# Audio Serial Clock Mode Controller

This block produces the bit clock and the frame (left/right) clock of a serial audio port. A strap input chooses between two roles. As clock master, the block divides an internal master clock running at 768 times the sample rate. It produces a bit clock at 64 times the sample rate and a frame clock at the sample rate. As clock slave, it copies the bit clock and frame clock that arrive from outside directly to its outputs.

A 2-bit source select records where the master clock comes from: the crystal input, or the incoming bit clock. The strap and the select are taken in only while reset is asserted. After that they stay frozen until the next reset. A sticky error output reports a reserved select value. It also reports a slave port that takes its master clock from the bit clock while the incoming bit clock runs at 48 times the sample rate, because that rate cannot feed the clock multiplier in that mode. The 48fs rate is recognised by counting bit clock rising edges between frame clock rising edges.

Top module: `audio_clk_mode_ctrl`

## Requirements
- R1: While `rst_n_i` is low, `frame_clk_o`, `bit_clk_o`, `use_bclk_src_o` and `cfg_err_o` are all 0, whatever the clock inputs do.
- R2: With the strap captured low (slave), `frame_clk_o` equals `frame_clk_i` and `bit_clk_o` equals `bit_clk_i` in the same cycle, without any register in the path, for both 48fs and 64fs input bit clocks.
- R3: With the strap captured high (master), `bit_clk_o` has a period of 12 master clock cycles and is low for 6 cycles, then high for 6. The first rise of `bit_clk_o` comes in the first bit period after reset.
- R4: In master mode, `frame_clk_o` has a period of 64 bit clock periods and is low for the first 32 of them. It changes only in the cycle where `bit_clk_o` falls, and `frame_clk_i` and `bit_clk_i` have no effect on either output.
- R5: `master_strap_i` and `src_sel_i` are captured on every clock edge while reset is held. Changes made after reset is released have no effect on any output until the next reset.
- R6: `use_bclk_src_o` is 1 exactly when the captured strap is 0 (slave) and the captured select is 2. Selects 0 and 1 in either mode, and select 2 in master mode, take the master clock from the crystal, and `use_bclk_src_o` is then 0.
- R7: A captured select of 3 (reserved) sets `cfg_err_o` within two cycles of reset release, in either mode.
- R8: In slave mode with select 2, a frame with exactly 48 bit clock rising edges between two consecutive frame clock rising edges sets `cfg_err_o`. The check skips the partial frame before the first frame clock rise. 64 edges per frame does not set `cfg_err_o`, and 48 edges per frame with select 0 or 1 does not set it either.
- R9: Once set, `cfg_err_o` stays 1 until the next reset, even if the input bit clock returns to 64fs, and a reset clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk_i | input | 1 | Internal master clock at 768fs |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside |
| master_strap_i | input | 1 | Role strap: 1 master, 0 slave; captured during reset |
| src_sel_i | input | 2 | Master clock source select; captured during reset; 3 is reserved |
| frame_clk_i | input | 1 | Incoming frame clock (slave mode), synchronous to mclk_i |
| bit_clk_i | input | 1 | Incoming bit clock (slave mode), synchronous to mclk_i |
| frame_clk_o | output | 1 | Outgoing frame clock at 1fs |
| bit_clk_o | output | 1 | Outgoing bit clock |
| use_bclk_src_o | output | 1 | 1 when the master clock is sourced from the incoming bit clock |
| cfg_err_o | output | 1 | Sticky configuration or rate error |

## Verification
Random trials draw the strap, the select and the incoming bit clock rate (48fs or 64fs). Each trial is checked for pass-through, divided clocks, source routing and the error flag. The error flag is the only output that separates a 48fs from a 64fs slave stream, and only under select 2. Master trials toggle the clock inputs at random, so any leak of those inputs into the divided outputs shows up as a waveform mismatch. Directed cases change the strap and select after reset to prove they are frozen. They also hold a 48fs error while the rate returns to 64fs, and a reserved select in master mode.

// File: rtl/acm_pkg.sv
`timescale 1ns/1ps
package acm_pkg;
  // captured role and source selection
  typedef struct packed {
    logic       master;
    logic [1:0] sel;
  } acm_cfg_t;

  localparam logic [1:0] SEL_BCLK_SRC = 2'd2;
  localparam logic [1:0] SEL_RESERVED = 2'd3;
endpackage

// File: rtl/acm_rst_sync.sv
`timescale 1ns/1ps
module acm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_one
      assign sync_d = 1'b1;
    end else begin : g_chain
      assign sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/acm_cfg_ctrl.sv
`timescale 1ns/1ps
module acm_cfg_ctrl
  import acm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_n_i,
  input  logic       strap_i,
  input  logic [1:0] sel_i,
  input  logic       low_rate_i,
  output logic       master_o,
  output logic       use_bclk_o,
  output logic       err_o
);
  acm_cfg_t cfg_q;
  acm_cfg_t cfg_d;
  logic     cap_en;
  logic     err_q;
  logic     err_d;

  // capture strap and select only while reset is held
  always_comb begin
    cap_en = !rst_n_i;
    cfg_d  = cfg_q;
    if (cap_en) begin
      cfg_d.master = strap_i;
      cfg_d.sel    = sel_i;
    end
  end

  always_ff @(posedge clk_i) begin
    cfg_q <= cfg_d;
  end

  always_comb begin
    err_d = err_q
          | (cfg_q.sel == SEL_RESERVED)
          | (low_rate_i && !cfg_q.master && (cfg_q.sel == SEL_BCLK_SRC));
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) err_q <= 1'b0;
    else          err_q <= err_d;
  end

  assign master_o   = rst_n_i & cfg_q.master;
  assign use_bclk_o = rst_n_i & !cfg_q.master & (cfg_q.sel == SEL_BCLK_SRC);
  assign err_o      = err_q;

  // R5
  cfg_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $past(rst_n_i) |-> $stable(cfg_q));

  // R7
  rsvd_sel_err_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (cfg_q.sel == SEL_RESERVED) |=> err_q);

  // R9
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    err_q |=> err_q);
endmodule

// File: rtl/acm_master_gen.sv
`timescale 1ns/1ps
module acm_master_gen #(
  parameter int MCLK_PER_BCLK  = 12,
  parameter int BCLK_PER_FRAME = 64
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic en_i,
  output logic bclk_o,
  output logic frame_o
);
  localparam int MC_W = $clog2(MCLK_PER_BCLK);
  localparam int BC_W = $clog2(BCLK_PER_FRAME);
  localparam logic [MC_W-1:0] MC_LAST = MC_W'(MCLK_PER_BCLK - 1);
  localparam logic [MC_W-1:0] MC_HALF = MC_W'(MCLK_PER_BCLK / 2);
  localparam logic [BC_W-1:0] BC_LAST = BC_W'(BCLK_PER_FRAME - 1);
  localparam logic [BC_W-1:0] BC_HALF = BC_W'(BCLK_PER_FRAME / 2);

  logic [MC_W-1:0] mcnt_q, mcnt_d;
  logic [BC_W-1:0] bcnt_q, bcnt_d;
  logic            bclk_q, bclk_d;
  logic            frame_q, frame_d;

  always_comb begin
    mcnt_d = mcnt_q;
    bcnt_d = bcnt_q;
    if (en_i) begin
      if (mcnt_q == MC_LAST) begin
        mcnt_d = '0;
        bcnt_d = (bcnt_q == BC_LAST) ? '0 : bcnt_q + BC_W'(1);
      end else begin
        mcnt_d = mcnt_q + MC_W'(1);
      end
    end
    // bit clock low in first half of a bit; frame low in first half of a frame
    bclk_d  = en_i && (mcnt_d >= MC_HALF);
    frame_d = en_i && (bcnt_d >= BC_HALF);
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      mcnt_q  <= '0;
      bcnt_q  <= '0;
      bclk_q  <= 1'b0;
      frame_q <= 1'b0;
    end else begin
      mcnt_q  <= mcnt_d;
      bcnt_q  <= bcnt_d;
      bclk_q  <= bclk_d;
      frame_q <= frame_d;
    end
  end

  assign bclk_o  = bclk_q;
  assign frame_o = frame_q;

  // R4
  frame_on_bclk_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (frame_q != $past(frame_q)) |-> $fell(bclk_q));

  // R3
  idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !en_i |=> (!bclk_q && !frame_q));
endmodule

// File: rtl/acm_rate_det.sv
`timescale 1ns/1ps
module acm_rate_det #(
  parameter int LOW_BITS = 48,
  parameter int MAX_BITS = 64
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic en_i,
  input  logic frame_i,
  input  logic bclk_i,
  output logic low_rate_o
);
  localparam int CNT_W = $clog2(MAX_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_LOW = CNT_W'(LOW_BITS);

  logic             frame_q, bclk_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             armed_q, armed_d;
  logic             low_q, low_d;
  logic             frame_rise, bclk_rise;

  always_comb begin
    frame_rise = en_i && frame_i && !frame_q;
    bclk_rise  = en_i && bclk_i && !bclk_q;
    cnt_d   = cnt_q;
    armed_d = armed_q;
    low_d   = 1'b0;
    if (frame_rise) begin
      low_d   = armed_q && (cnt_q == CNT_LOW);
      armed_d = 1'b1;
      cnt_d   = bclk_rise ? CNT_W'(1) : '0;
    end else if (bclk_rise && (cnt_q != CNT_MAX)) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      frame_q <= 1'b0;
      bclk_q  <= 1'b0;
      cnt_q   <= '0;
      armed_q <= 1'b0;
      low_q   <= 1'b0;
    end else begin
      frame_q <= frame_i;
      bclk_q  <= bclk_i;
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
      low_q   <= low_d;
    end
  end

  assign low_rate_o = low_q;

  // R8
  low_rate_at_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    low_q |-> $rose(frame_q));
endmodule

// File: rtl/audio_clk_mode_ctrl.sv
`timescale 1ns/1ps
module audio_clk_mode_ctrl #(
  parameter int MCLK_PER_BCLK  = 12,
  parameter int BCLK_PER_FRAME = 64,
  parameter int LOW_RATE_BITS  = 48,
  parameter int SYNC_STAGES    = 2
) (
  input  logic       mclk_i,
  input  logic       rst_n_i,
  input  logic       master_strap_i,
  input  logic [1:0] src_sel_i,
  input  logic       frame_clk_i,
  input  logic       bit_clk_i,
  output logic       frame_clk_o,
  output logic       bit_clk_o,
  output logic       use_bclk_src_o,
  output logic       cfg_err_o
);
  logic rst_sync_n;
  logic master;
  logic low_rate;
  logic m_bclk, m_frame;

  acm_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk_i   (mclk_i),
    .arst_n_i(rst_n_i),
    .rst_n_o (rst_sync_n)
  );

  acm_cfg_ctrl u_cfg (
    .clk_i     (mclk_i),
    .rst_n_i   (rst_sync_n),
    .strap_i   (master_strap_i),
    .sel_i     (src_sel_i),
    .low_rate_i(low_rate),
    .master_o  (master),
    .use_bclk_o(use_bclk_src_o),
    .err_o     (cfg_err_o)
  );

  acm_master_gen #(
    .MCLK_PER_BCLK (MCLK_PER_BCLK),
    .BCLK_PER_FRAME(BCLK_PER_FRAME)
  ) u_gen (
    .clk_i  (mclk_i),
    .rst_n_i(rst_sync_n),
    .en_i   (master),
    .bclk_o (m_bclk),
    .frame_o(m_frame)
  );

  acm_rate_det #(
    .LOW_BITS(LOW_RATE_BITS),
    .MAX_BITS(BCLK_PER_FRAME)
  ) u_det (
    .clk_i     (mclk_i),
    .rst_n_i   (rst_sync_n),
    .en_i      (!master),
    .frame_i   (frame_clk_i),
    .bclk_i    (bit_clk_i),
    .low_rate_o(low_rate)
  );

  // output select: held low in reset, generated in master, mirrored in slave
  always_comb begin
    if (!rst_sync_n) begin
      frame_clk_o = 1'b0;
      bit_clk_o   = 1'b0;
    end else if (master) begin
      frame_clk_o = m_frame;
      bit_clk_o   = m_bclk;
    end else begin
      frame_clk_o = frame_clk_i;
      bit_clk_o   = bit_clk_i;
    end
  end
endmodule

// File: tb/audio_clk_mode_ctrl_tb_top.sv
`timescale 1ns/1ps
module audio_clk_mode_ctrl_tb_top;
  localparam int FRAME_MCLK = 768;
  localparam int M_PER_B    = 12;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       strap;
  logic [1:0] sel;
  logic       frame_i, bit_i;
  logic       frame_o, bit_o, use_bclk, err;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;
  int unsigned seed_init;

  always #2.5 clk = ~clk;

  audio_clk_mode_ctrl dut_i (
    .mclk_i        (clk),
    .rst_n_i       (rst_n),
    .master_strap_i(strap),
    .src_sel_i     (sel),
    .frame_clk_i   (frame_i),
    .bit_clk_i     (bit_i),
    .frame_clk_o   (frame_o),
    .bit_clk_o     (bit_o),
    .use_bclk_src_o(use_bclk),
    .cfg_err_o     (err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit exp_err(input bit s, input logic [1:0] sl, input int bits);
    return (sl == 2'd3) || (!s && sl == 2'd2 && bits == 48);
  endfunction

  function automatic bit exp_route(input bit s, input logic [1:0] sl);
    return !s && sl == 2'd2;
  endfunction

  // R1 checked while reset is held with clock inputs high
  task automatic apply_reset(input bit s, input logic [1:0] sl);
    @(negedge clk);
    rst_n = 1'b0; strap = s; sel = sl; frame_i = 1'b1; bit_i = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk({frame_o, bit_o, use_bclk, err} == 4'b0, "R1", "outputs in reset",
        {frame_o, bit_o, use_bclk, err}, 0);
    @(negedge clk);
    rst_n = 1'b1; frame_i = 1'b0; bit_i = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic run_slave(input int bits, input int frames, output int bad);
    int per;
    int half;
    per  = FRAME_MCLK / bits;
    half = per / 2;
    bad  = 0;
    for (int f = 0; f < frames; f++) begin
      for (int c = 0; c < FRAME_MCLK; c++) begin
        @(negedge clk);
        bit_i   = (c % per) >= half;
        frame_i = (c / per) >= (bits / 2);
        #1;
        if (frame_o !== frame_i || bit_o !== bit_i) bad++;
      end
    end
  endtask

  task automatic run_master(input int frames, output int bad_b, output int bad_f);
    int k;
    int guard;
    bad_b = 0; bad_f = 0; guard = 0;
    do begin
      @(negedge clk);
      bit_i = 1'($urandom); frame_i = 1'($urandom);
      #1;
      guard++;
    end while (bit_o !== 1'b1 && guard < 40);
    if (guard >= 40) bad_b++;
    k = M_PER_B / 2;
    if (frame_o !== 1'b0) bad_f++;
    for (int n = 0; n < frames * FRAME_MCLK; n++) begin
      @(negedge clk);
      bit_i = 1'($urandom); frame_i = 1'($urandom);
      #1;
      k++;
      if (bit_o !== ((k % M_PER_B) >= M_PER_B / 2)) bad_b++;
      if (frame_o !== (((k / M_PER_B) % 64) >= 32)) bad_f++;
    end
  endtask

  task automatic trial(input bit s, input logic [1:0] sl, input int bits);
    int bad, bb, bf;
    apply_reset(s, sl);
    if (s) begin
      run_master(2, bb, bf);
      chk(bb == 0, "R3", "bit clock mismatches", bb, 0);
      chk(bf == 0, "R4", "frame clock mismatches", bf, 0);
    end else begin
      run_slave(bits, 3, bad);
      chk(bad == 0, "R2", "pass-through mismatches", bad, 0);
    end
    chk(use_bclk == exp_route(s, sl), "R6", "source route", use_bclk, exp_route(s, sl));
    chk(err == exp_err(s, sl, bits), (sl == 2'd3) ? "R7" : "R8", "error flag",
        err, exp_err(s, sl, bits));
  endtask

  initial begin
    int bad, bb, bf;
    rst_n = 1'b0; strap = 1'b0; sel = 2'd0; frame_i = 1'b0; bit_i = 1'b0;
    seed_init = $urandom(32'd20417);

    // R5: changes after release are ignored (slave stays slave)
    apply_reset(1'b0, 2'd0);
    strap = 1'b1; sel = 2'd3;
    run_slave(64, 3, bad);
    chk(bad == 0, "R5", "slave kept after strap change", bad, 0);
    chk(err == 1'b0, "R5", "no error from late reserved select", err, 0);
    chk(use_bclk == 1'b0, "R5", "route kept", use_bclk, 0);

    // R5: master stays master after strap drops
    apply_reset(1'b1, 2'd1);
    strap = 1'b0; sel = 2'd2;
    run_master(2, bb, bf);
    chk(bb == 0 && bf == 0, "R5", "master kept after strap change", bb + bf, 0);
    chk(use_bclk == 1'b0, "R5", "route after late select change", use_bclk, 0);

    // R8 then R9: 48fs with select 2 flags, stays set at 64fs
    apply_reset(1'b0, 2'd2);
    chk(use_bclk == 1'b1, "R6", "slave select 2 route", use_bclk, 1);
    run_slave(48, 3, bad);
    chk(err == 1'b1, "R8", "48fs under select 2", err, 1);
    run_slave(64, 3, bad);
    chk(err == 1'b1, "R9", "error held after rate recovers", err, 1);
    apply_reset(1'b0, 2'd2);
    chk(err == 1'b0, "R9", "error cleared by reset", err, 0);
    run_slave(64, 3, bad);
    chk(err == 1'b0, "R8", "64fs under select 2", err, 0);

    // R8: 48fs with select 1 is legal
    apply_reset(1'b0, 2'd1);
    run_slave(48, 3, bad);
    chk(err == 1'b0, "R8", "48fs under select 1", err, 0);

    // R7: reserved select in master mode
    apply_reset(1'b1, 2'd3);
    repeat (2) @(negedge clk);
    #1;
    chk(err == 1'b1, "R7", "reserved select master", err, 1);

    // random trials
    for (int t = 0; t < 12; t++) begin
      bit         rs;
      logic [1:0] rsel;
      int         rbits;
      rs    = 1'($urandom);
      rsel  = 2'($urandom);
      rbits = ($urandom % 2) ? 48 : 64;
      trial(rs, rsel, rbits);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end
endmodule